// File: doc/BRIEF.md
# Status LED Pattern Sequencer

This block drives one status LED. Control logic asks for one of four display modes: steady off, steady on, a slow flash with a one-second period, or a fast flash with an eighth-of-a-second period. Both flash modes have a 50% duty cycle. A single prescaler counter, sized by the parameter `TICKS_PER_SEC`, times both flash rates. Both rates are decoded from that one counter, so they always stay in phase.

After reset the block first shows a power-up indication and only then follows the requested mode. A strap input selects the indication.

- Strap low: the block starts an activation attempt and shows the fast flash for at least half a second. The indication then continues until the activation-success flag is seen, after which the block moves straight to the requested mode with no gap.
- Strap high: the LED is held off for exactly one second. The block then moves to the requested mode, and the success flag plays no part.

Mode requests that arrive during either indication are held in a register. The most recent one takes effect when the indication ends.

Top module: `stat_led_seq`

## Requirements
- R1: While reset is held, the LED reads 1 if the strap is 0 and reads 0 if the strap is 1.
- R2: With the strap at 0, the LED shows the fast flash for at least TICKS_PER_SEC/2 cycles after reset, even if the success flag is already high. The flash starts on the high half and toggles every TICKS_PER_SEC/16 cycles.
- R3: While the success flag stays low, the activation-attempt fast flash continues without limit, past its minimum length.
- R4: The attempt ends in the cycle after the first clock edge at which the minimum length has been met and the success flag is high. From that cycle the requested mode is shown, starting from the beginning of its pattern.
- R5: With the strap at 1, the LED is 0 for exactly TICKS_PER_SEC cycles after reset and then shows the requested mode. The success flag has no effect during this time.
- R6: Mode request encoding: 0 = steady off, 1 = steady on, 2 = slow flash, 3 = fast flash. The slow flash is high for TICKS_PER_SEC/2 cycles and then low for the same number. The fast flash is high for TICKS_PER_SEC/16 cycles and then low for the same number.
- R7: A change of the requested mode takes effect one cycle later, and the flash pattern restarts at its high half. Requesting the mode already shown does not disturb the pattern.
- R8: The strap is captured on the last clock edge at which reset is asserted. Strap changes after reset do not alter the indication.
- R9: Mode requests made during the power-up indication do not affect the LED. The last request present when the indication ends is the mode shown afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_no_act | input | 1 | Power-up strap: 0 = attempt activation, 1 = one-second off pulse only |
| act_ok | input | 1 | Activation-success flag from control logic |
| mode_req | input | 2 | Requested display mode (encoding in R6) |
| led | output | 1 | LED drive level |

## Verification
The hardest case to reach is an activation attempt that outlasts its minimum length. The success flag must be held low until well after the half-second point and then raised at a chosen cycle. That is the only way to see both the open-ended flashing and the clean handover into a slow flash that restarts from its high half. The bench runs a short `TICKS_PER_SEC`, so this point comes within about a hundred cycles. It raises the flag on a cycle it selects and then walks the following pattern cycle by cycle. A second scenario changes the mode request several times inside the one-second off pulse. This shows that only the request present at the end of the pulse takes effect.

// File: rtl/stat_led_pkg.sv
package stat_led_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_SLOW = 2'd2,
    MODE_FAST = 2'd3
  } led_mode_e;

  typedef enum logic [1:0] {
    SEQ_ATTEMPT = 2'd0,
    SEQ_LIFE    = 2'd1,
    SEQ_NORMAL  = 2'd2
  } seq_e;

  // Level of a 50% flash of the given period, at the given phase count.
  function automatic logic flash_level(input int unsigned phase,
                                       input int unsigned period);
    return (phase % period) < (period / 2);
  endfunction

endpackage

// File: rtl/stat_led_tbase.sv
module stat_led_tbase
  import stat_led_pkg::*;
#(
  parameter int unsigned TPS = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic slow_lvl,
  output logic fast_lvl
);

  localparam int unsigned PH_W     = $clog2(TPS);
  localparam int unsigned SLOW_PER = TPS;
  localparam int unsigned FAST_PER = TPS / 8;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (phase == PH_W'(TPS - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Both rates are decoded from the one counter, so they stay aligned.
  always_comb begin
    slow_lvl = flash_level(32'(phase), SLOW_PER);
    fast_lvl = flash_level(32'(phase), FAST_PER);
  end

endmodule

// File: rtl/stat_led_boot.sv
module stat_led_boot
  import stat_led_pkg::*;
#(
  parameter int unsigned TPS = 1_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_no_act,
  input  logic       act_ok,
  output logic [1:0] seq,
  output logic       att_min_met,
  output logic       win_exit
);

  localparam int unsigned ATT_CYC  = TPS / 2;
  localparam int unsigned LIFE_CYC = TPS;
  localparam int unsigned WIN_W    = $clog2(LIFE_CYC + 1);

  seq_e             seq_q;
  logic [WIN_W-1:0] win_cnt;
  logic             life_done;

  assign att_min_met = win_cnt >= WIN_W'(ATT_CYC - 1);
  assign life_done   = win_cnt == WIN_W'(LIFE_CYC - 1);
  assign win_exit    = ((seq_q == SEQ_ATTEMPT) && att_min_met && act_ok) ||
                       ((seq_q == SEQ_LIFE) && life_done);
  assign seq         = seq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= strap_no_act ? SEQ_LIFE : SEQ_ATTEMPT;
      win_cnt <= '0;
    end else begin
      if (win_exit) begin
        seq_q <= SEQ_NORMAL;
      end
      if ((seq_q != SEQ_NORMAL) && (win_cnt != WIN_W'(LIFE_CYC))) begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stat_led_mux.sv
module stat_led_mux
  import stat_led_pkg::*;
(
  input  logic [1:0] seq,
  input  logic [1:0] mode_q,
  input  logic       slow_lvl,
  input  logic       fast_lvl,
  output logic       led
);

  always_comb begin
    led = 1'b0;
    case (seq)
      SEQ_ATTEMPT: led = fast_lvl;
      SEQ_LIFE:    led = 1'b0;
      SEQ_NORMAL: begin
        case (mode_q)
          MODE_OFF:  led = 1'b0;
          MODE_ON:   led = 1'b1;
          MODE_SLOW: led = slow_lvl;
          MODE_FAST: led = fast_lvl;
          default:   led = 1'b0;
        endcase
      end
      default: led = 1'b0;
    endcase
  end

endmodule

// File: rtl/stat_led_seq.sv
module stat_led_seq
  import stat_led_pkg::*;
#(
  // Must be a multiple of 16 so both half-periods are whole cycles.
  parameter int unsigned TICKS_PER_SEC = 1_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_no_act,
  input  logic       act_ok,
  input  logic [1:0] mode_req,
  output logic       led
);

  logic [1:0] seq;
  logic [1:0] mode_q;
  logic       att_min_met;
  logic       win_exit;
  logic       mode_chg;
  logic       restart;
  logic       slow_lvl;
  logic       fast_lvl;

  // Requests are always registered; they only show once seq is NORMAL.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
    end else begin
      mode_q <= mode_req;
    end
  end

  assign mode_chg = (seq == SEQ_NORMAL) && (mode_req != mode_q);
  assign restart  = win_exit || mode_chg;

  stat_led_boot #(.TPS(TICKS_PER_SEC)) boot_i (
    .clk          (clk),
    .rst          (rst),
    .strap_no_act (strap_no_act),
    .act_ok       (act_ok),
    .seq          (seq),
    .att_min_met  (att_min_met),
    .win_exit     (win_exit)
  );

  stat_led_tbase #(.TPS(TICKS_PER_SEC)) tbase_i (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .slow_lvl (slow_lvl),
    .fast_lvl (fast_lvl)
  );

  stat_led_mux mux_i (
    .seq      (seq),
    .mode_q   (mode_q),
    .slow_lvl (slow_lvl),
    .fast_lvl (fast_lvl),
    .led      (led)
  );

endmodule

// File: rtl/stat_led_chk.sv
module stat_led_chk
  import stat_led_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       act_ok,
  input logic [1:0] mode_req,
  input logic       led,
  input logic [1:0] seq,
  input logic [1:0] mode_q,
  input logic       att_min_met,
  input logic       restart
);

  assert_attempt_min_R2: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_ATTEMPT && !att_min_met) |=> (seq == SEQ_ATTEMPT));

  assert_wait_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_ATTEMPT && !act_ok) |=> (seq == SEQ_ATTEMPT));

  assert_life_low_R5: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_LIFE) |-> !led);

  assert_steady_on_R6: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_NORMAL && mode_q == MODE_ON && mode_req == MODE_ON) |=> led);

  assert_restart_high_R7: assert property (@(posedge clk) disable iff (rst)
    (restart && mode_req != MODE_OFF) |=> led);

endmodule

bind stat_led_seq stat_led_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .act_ok      (act_ok),
  .mode_req    (mode_req),
  .led         (led),
  .seq         (seq),
  .mode_q      (mode_q),
  .att_min_met (att_min_met),
  .restart     (restart)
);

// File: tb/stat_led_seq_tb_top.sv
module stat_led_seq_tb_top;

  localparam int unsigned TPS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_no_act = 1'b0;
  logic       act_ok = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic       led;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  stat_led_seq #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .strap_no_act (strap_no_act),
    .act_ok       (act_ok),
    .mode_req     (mode_req),
    .led          (led)
  );

  function automatic logic slow_exp(input int j);
    return (j % TPS) < (TPS / 2);
  endfunction

  function automatic logic fast_exp(input int j);
    return (j % (TPS / 8)) < (TPS / 16);
  endfunction

  task automatic check_led(input string req, input logic exp);
    checks++;
    if (led !== exp) begin
      fails++;
      $display("FAIL %s: led=%0b expected %0b at %0t", req, led, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Hold reset, check the reset state (R1), release. Leaves cycle 0 current.
  task automatic reset_with(input logic strap_v);
    @(negedge clk);
    rst = 1'b1;
    strap_no_act = strap_v;
    repeat (3) @(negedge clk);
    check_led("R1", !strap_v);
    rst = 1'b0;
  endtask

  task automatic t_attempt_min();
    act_ok = 1'b1;
    mode_req = 2'd1;
    reset_with(1'b0);
    for (int k = 0; k < TPS / 2; k++) begin
      check_led("R2", fast_exp(k));
      step();
    end
    for (int k = 0; k < 8; k++) begin
      check_led("R4", 1'b1);
      step();
    end
  endtask

  task automatic t_attempt_long();
    act_ok = 1'b0;
    mode_req = 2'd2;
    reset_with(1'b0);
    for (int k = 0; k < 80; k++) begin
      check_led("R3", fast_exp(k));
      step();
    end
    act_ok = 1'b1;
    check_led("R3", fast_exp(80));
    step();
    for (int j = 0; j < 70; j++) begin
      check_led("R4", slow_exp(j));
      step();
    end
  endtask

  task automatic t_life_pulse();
    act_ok = 1'b1;
    mode_req = 2'd3;
    reset_with(1'b1);
    strap_no_act = 1'b0;  // R8: ignored after reset
    for (int k = 0; k < TPS; k++) begin
      check_led("R5", 1'b0);
      step();
    end
    for (int j = 0; j < 20; j++) begin
      check_led("R8", fast_exp(j));
      step();
    end
  endtask

  task automatic t_window_requests();
    act_ok = 1'b0;
    mode_req = 2'd1;
    reset_with(1'b1);
    for (int k = 0; k < TPS; k++) begin
      if (k == 20) mode_req = 2'd0;
      if (k == 40) mode_req = 2'd2;
      check_led("R9", 1'b0);
      step();
    end
    for (int j = 0; j < 40; j++) begin
      check_led("R9", slow_exp(j));
      step();
    end
  endtask

  task automatic t_mode_changes();
    // Continues from slow flash at phase 40 (low half).
    mode_req = 2'd3;
    step();
    for (int j = 0; j < 6; j++) begin
      check_led("R7", fast_exp(j));
      step();
    end
    mode_req = 2'd2;
    step();
    for (int j = 0; j < 12; j++) begin
      if (j == 3) mode_req = 2'd2;  // same mode, no restart
      check_led("R7", slow_exp(j));
      step();
    end
    mode_req = 2'd0;
    step();
    for (int j = 0; j < 5; j++) begin
      check_led("R6", 1'b0);
      step();
    end
    mode_req = 2'd1;
    step();
    for (int j = 0; j < 5; j++) begin
      check_led("R6", 1'b1);
      step();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100_000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_attempt_min();
    t_attempt_long();
    t_life_pulse();
    t_window_requests();
    t_mode_changes();
    finish_run();
  end

endmodule